// File: doc/BRIEF.md
# Cluster-Buffered Dual-Address DMA Channel

This block is one DMA channel that copies a run of bytes from a source region to a destination region. It works in bursts called clusters. For each cluster it reads a run of consecutive bytes from the source address into a small internal buffer. It then writes those bytes, in the same order, to consecutive destination addresses. The reads and writes of one cluster form a single locked bus sequence, so no other bus master can get in between them. Between clusters the lock is dropped and the channel asks for the bus again.

Software programs five registers: source address, destination address, cluster size, total byte count, and control. The control register holds the channel enable and the transfer-end enable. Writing the enable starts the channel. It keeps moving clusters until the byte count is used up, then clears its own enable. A cluster size of one gives plain read-then-write block copying. An optional transfer-end strobe marks the last write of the whole transfer.

Top module: `clust_dma`

## Requirements
- R1: After reset all five registers read as zero and bus_req, bus_lock and xfer_end are low. The register indices are: 0 source address, 1 destination address, 2 cluster size, 3 remaining byte count, 4 control. In the control register, bit 0 is the channel enable and bit 1 is the transfer-end enable.
- R2: A cluster starts only after bus_gnt has been seen high while the channel requests the bus. bus_lock rises only in the cycle after a cycle with bus_gnt high.
- R3: Each cluster of length L = min(effective cluster size, remaining count) is made of L reads (bus_we low) at ascending source addresses, followed by L writes (bus_we high) at ascending destination addresses. Every cycle with bus_lock high carries exactly one such access.
- R4: bus_lock stays high without a break from the first read of a cluster to its last write. It falls for at least one cycle between clusters, so a transfer shows one lock assertion per cluster.
- R5: The destination receives the bytes in source order, with their values unchanged.
- R6: The source and destination addresses keep advancing across clusters. After a transfer of N bytes, the two registers read back as their start values plus N, and the count reads back as zero.
- R7: When the count reaches zero, the engine clears control bit 0 and stops requesting the bus. Setting the enable while the count is zero starts no bus activity.
- R8: If control bit 1 is set, xfer_end is high for exactly one cycle, and that cycle is the final write of the transfer. If the bit is clear, xfer_end stays low.
- R9: A cluster size of 1 gives strictly alternating single reads and single writes, with the lock dropped after each write.
- R10: A programmed cluster size of 0 acts as 1. A size above CLUST_MAX acts as CLUST_MAX.
- R11: If the enable is cleared while a cluster is in progress, the cluster still completes and the channel then goes idle. Setting the enable again resumes from the current addresses and count.
- R12: While the channel is busy, software writes to the source, destination, cluster-size and count registers are ignored.
- R13: dma_ack is never asserted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register index for both read and write |
| reg_wdata | input | REG_W | Register write data |
| reg_rdata | output | REG_W | Read data of the selected register |
| bus_req | output | 1 | Bus request, high while the channel is active |
| bus_gnt | input | 1 | Bus grant from the arbiter |
| bus_lock | output | 1 | Lock; high on every access cycle of a cluster |
| bus_we | output | 1 | High for a write access, low for a read |
| bus_addr | output | AW | Access address |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled in read cycles |
| xfer_end | output | 1 | Transfer-end strobe on the final write |
| dma_ack | output | 1 | Acknowledge output, held low in this mode |

## Verification
Several properties are checked on every cycle: lock rises only after a grant, lock is held until the last write of a cluster, reads always hand over to writes, the buffer index stays inside the cluster length, the transfer-end strobe falls only on a locked write, and the source address only ever steps by one while the channel is busy. Other behaviour can only be shown by the bench's scenarios. That covers byte order and data integrity at the destination, the exact access pattern for a given cluster size and count, the clamping of cluster sizes, the write-back values of the registers, and the effect of software writes during a transfer. It also covers stopping after a cluster when the enable is cleared, and resuming afterwards.

// File: rtl/clust_dma_pkg.sv
package clust_dma_pkg;
   typedef enum logic [1:0] {ST_IDLE, ST_REQ, ST_RD, ST_WR} dma_st_t;

   localparam logic [2:0] RI_SRC = 3'd0;
   localparam logic [2:0] RI_DST = 3'd1;
   localparam logic [2:0] RI_CSZ = 3'd2;
   localparam logic [2:0] RI_CNT = 3'd3;
   localparam logic [2:0] RI_CTL = 3'd4;
endpackage

// File: rtl/clust_dma_regs.sv
module clust_dma_regs
   import clust_dma_pkg::*;
#(
   parameter int AW    = 16,
   parameter int CW    = 16,
   parameter int LW    = 6,
   parameter int REG_W = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr,
   input  logic [2:0]       sel,
   input  logic [REG_W-1:0] wdata,
   output logic [REG_W-1:0] rdata,
   input  logic             busy,
   input  logic             src_inc,
   input  logic             dst_inc,
   input  logic             cnt_dec,
   input  logic [LW-1:0]    dec_amt,
   input  logic             en_clr,
   output logic [AW-1:0]    src,
   output logic [AW-1:0]    dst,
   output logic [LW-1:0]    csz,
   output logic [CW-1:0]    cnt,
   output logic             en,
   output logic             end_en
);
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src    <= '0;
         dst    <= '0;
         csz    <= '0;
         cnt    <= '0;
         en     <= 1'b0;
         end_en <= 1'b0;
      end else begin
         if (src_inc) src <= src + 1'b1;
         if (dst_inc) dst <= dst + 1'b1;
         if (cnt_dec) cnt <= cnt - CW'(dec_amt);
         if (en_clr)  en  <= 1'b0;
         if (wr) begin
            case (sel)
               RI_SRC: if (!busy) src <= wdata[AW-1:0];
               RI_DST: if (!busy) dst <= wdata[AW-1:0];
               RI_CSZ: if (!busy) csz <= wdata[LW-1:0];
               RI_CNT: if (!busy) cnt <= wdata[CW-1:0];
               RI_CTL: begin
                  en     <= wdata[0];
                  end_en <= wdata[1];
               end
               default: ;
            endcase
         end
      end
   end

   always_comb begin
      case (sel)
         RI_SRC:  rdata = REG_W'(src);
         RI_DST:  rdata = REG_W'(dst);
         RI_CSZ:  rdata = REG_W'(csz);
         RI_CNT:  rdata = REG_W'(cnt);
         RI_CTL:  rdata = REG_W'({end_en, en});
         default: rdata = '0;
      endcase
   end

   // R12
   src_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
      ($past(busy) && busy && !$stable(src)) |-> (src == AW'($past(src) + 1'b1)));
endmodule

// File: rtl/clust_dma_buf.sv
module clust_dma_buf #(
   parameter int DEPTH = 32,
   parameter int LW    = 6
) (
   input  logic          clk,
   input  logic          we,
   input  logic [LW-1:0] widx,
   input  logic [7:0]    wdat,
   input  logic [LW-1:0] ridx,
   output logic [7:0]    rdat
);
   localparam int IW = (DEPTH > 1) ? $clog2(DEPTH) : 1;

   generate
      if (DEPTH == 1) begin : g_one
         logic [7:0] hold_q;
         always_ff @(posedge clk) if (we) hold_q <= wdat;
         assign rdat = hold_q;
      end else begin : g_arr
         logic [7:0] store_q [DEPTH];
         always_ff @(posedge clk) if (we) store_q[widx[IW-1:0]] <= wdat;
         assign rdat = store_q[ridx[IW-1:0]];
      end
   endgenerate
endmodule

// File: rtl/clust_dma_fsm.sv
module clust_dma_fsm
   import clust_dma_pkg::*;
#(
   parameter int CW   = 16,
   parameter int LW   = 6,
   parameter int CMAX = 32
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          en,
   input  logic          end_en,
   input  logic [LW-1:0] csz,
   input  logic [CW-1:0] cnt,
   input  logic          bus_gnt,
   output dma_st_t       st,
   output logic [LW-1:0] idx,
   output logic [LW-1:0] len,
   output logic          busy,
   output logic          bus_req,
   output logic          bus_lock,
   output logic          bus_we,
   output logic          src_inc,
   output logic          dst_inc,
   output logic          buf_we,
   output logic          cnt_dec,
   output logic          en_clr,
   output logic          xfer_end
);
   logic [LW-1:0] csz_eff;
   logic          last;
   logic          final_cl;

   always_comb begin
      if (csz == '0)              csz_eff = LW'(1);
      else if (csz > LW'(CMAX))   csz_eff = LW'(CMAX);
      else                        csz_eff = csz;
   end

   assign len      = (cnt < CW'(csz_eff)) ? LW'(cnt) : csz_eff;
   assign last     = (idx == LW'(len - 1'b1));
   assign final_cl = (cnt == CW'(len));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         st  <= ST_IDLE;
         idx <= '0;
      end else begin
         case (st)
            ST_IDLE: if (en && cnt != '0) st <= ST_REQ;
            ST_REQ: begin
               if (!en)          st <= ST_IDLE;
               else if (bus_gnt) st <= ST_RD;
               idx <= '0;
            end
            ST_RD: begin
               if (last) begin
                  st  <= ST_WR;
                  idx <= '0;
               end else idx <= idx + 1'b1;
            end
            ST_WR: begin
               if (last) begin
                  st  <= (en && !final_cl) ? ST_REQ : ST_IDLE;
                  idx <= '0;
               end else idx <= idx + 1'b1;
            end
            default: st <= ST_IDLE;
         endcase
      end
   end

   assign busy     = (st != ST_IDLE);
   assign bus_req  = busy;
   assign bus_lock = (st == ST_RD) || (st == ST_WR);
   assign bus_we   = (st == ST_WR);
   assign src_inc  = (st == ST_RD);
   assign buf_we   = (st == ST_RD);
   assign dst_inc  = (st == ST_WR);
   assign cnt_dec  = (st == ST_WR) && last;
   assign en_clr   = (st == ST_WR) && last && final_cl;
   assign xfer_end = end_en && (st == ST_WR) && last && final_cl;

   // R2
   lock_after_gnt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(bus_lock) |-> $past(bus_gnt));
   // R3
   rd_then_wr_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (st == ST_RD && last) |=> (st == ST_WR));
   // R3
   idx_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
      bus_lock |-> (idx < len));
   // R4
   lock_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_lock && !(bus_we && last)) |=> bus_lock);
   // R7
   stop_after_final_chk: assert property (@(posedge clk) disable iff (!rst_n)
      en_clr |=> (st == ST_IDLE && !en));
   // R8
   end_on_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
      xfer_end |-> (bus_we && bus_lock && end_en));
endmodule

// File: rtl/clust_dma.sv
module clust_dma
   import clust_dma_pkg::*;
#(
   parameter int AW        = 16,
   parameter int CW        = 16,
   parameter int CLUST_MAX = 32,
   parameter int REG_W     = 32
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_sel,
   input  logic [REG_W-1:0] reg_wdata,
   output logic [REG_W-1:0] reg_rdata,
   output logic             bus_req,
   input  logic             bus_gnt,
   output logic             bus_lock,
   output logic             bus_we,
   output logic [AW-1:0]    bus_addr,
   output logic [7:0]       bus_wdata,
   input  logic [7:0]       bus_rdata,
   output logic             xfer_end,
   output logic             dma_ack
);
   localparam int LW = $clog2(CLUST_MAX + 1);

   generate
      if (CLUST_MAX < 1 || CLUST_MAX > 32) begin : g_bad_cmax
         $error("CLUST_MAX must be within 1..32");
      end
      if (AW > REG_W || CW > REG_W || CW < LW) begin : g_bad_width
         $error("address or count width does not fit the register port");
      end
   endgenerate

   dma_st_t       st;
   logic [LW-1:0] idx, len, csz;
   logic [AW-1:0] src, dst;
   logic [CW-1:0] cnt;
   logic          en, end_en, busy;
   logic          src_inc, dst_inc, buf_we, cnt_dec, en_clr;

   clust_dma_regs #(.AW(AW), .CW(CW), .LW(LW), .REG_W(REG_W)) regs_i (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .sel(reg_sel), .wdata(reg_wdata),
      .rdata(reg_rdata), .busy(busy), .src_inc(src_inc), .dst_inc(dst_inc),
      .cnt_dec(cnt_dec), .dec_amt(len), .en_clr(en_clr), .src(src), .dst(dst),
      .csz(csz), .cnt(cnt), .en(en), .end_en(end_en)
   );

   clust_dma_fsm #(.CW(CW), .LW(LW), .CMAX(CLUST_MAX)) fsm_i (
      .clk(clk), .rst_n(rst_n), .en(en), .end_en(end_en), .csz(csz), .cnt(cnt),
      .bus_gnt(bus_gnt), .st(st), .idx(idx), .len(len), .busy(busy),
      .bus_req(bus_req), .bus_lock(bus_lock), .bus_we(bus_we),
      .src_inc(src_inc), .dst_inc(dst_inc), .buf_we(buf_we), .cnt_dec(cnt_dec),
      .en_clr(en_clr), .xfer_end(xfer_end)
   );

   clust_dma_buf #(.DEPTH(CLUST_MAX), .LW(LW)) buf_i (
      .clk(clk), .we(buf_we), .widx(idx), .wdat(bus_rdata),
      .ridx(idx), .rdat(bus_wdata)
   );

   assign bus_addr = bus_we ? dst : src;
   assign dma_ack  = 1'b0;
endmodule

// File: tb/clust_dma_tb_top.sv
module clust_dma_tb_top;
   import clust_dma_pkg::*;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_sel = 3'd0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        bus_req, bus_lock, bus_we, xfer_end, dma_ack;
   logic        bus_gnt = 1'b0;
   logic [15:0] bus_addr;
   logic [7:0]  bus_wdata, bus_rdata;

   logic [7:0]  mem [1024];
   logic        log_we [512];
   logic [15:0] log_addr [512];
   int log_n = 0, lock_rises = 0, end_cnt = 0, end_idx = -1;
   int ack_seen = 0, gnt_viol = 0;
   int checks = 0, fails = 0;
   logic prev_lock = 1'b0, prev_gnt = 1'b0;

   always #(CLK_PERIOD/2) clk = ~clk;

   clust_dma dut_i (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_sel(reg_sel),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .bus_req(bus_req),
      .bus_gnt(bus_gnt), .bus_lock(bus_lock), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
      .xfer_end(xfer_end), .dma_ack(dma_ack)
   );

   assign bus_rdata = mem[bus_addr[9:0]];

   always @(negedge clk)
      bus_gnt <= bus_lock | (bus_req & ($urandom % 3 == 0));

   always @(posedge clk) begin
      if (rst_n) begin
         if (dma_ack) ack_seen++;
         if (bus_lock && !prev_lock && !prev_gnt) gnt_viol++;
         if (bus_lock && !prev_lock) lock_rises++;
         if (xfer_end) begin
            end_cnt++;
            end_idx = bus_lock ? log_n : -1;
         end
         if (bus_lock) begin
            if (log_n < 512) begin
               log_we[log_n]   = bus_we;
               log_addr[log_n] = bus_addr;
            end
            log_n++;
            if (bus_we) mem[bus_addr[9:0]] = bus_wdata;
         end
      end
      prev_lock = bus_lock;
      prev_gnt  = bus_gnt;
   end

   task automatic chk(input bit ok, input string msg, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", msg, act, exp);
      end
   endtask

   task automatic wr_reg(input logic [2:0] s, input logic [31:0] v);
      @(negedge clk);
      reg_wr = 1'b1; reg_sel = s; reg_wdata = v;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_reg(input logic [2:0] s, output logic [31:0] v);
      @(negedge clk);
      reg_sel = s;
      #1 v = reg_rdata;
   endtask

   task automatic clear_logs();
      log_n = 0; lock_rises = 0; end_cnt = 0; end_idx = -1;
   endtask

   task automatic wait_idle();
      logic [31:0] v;
      for (int k = 0; k < 4000; k++) begin
         rd_reg(RI_CTL, v);
         if (!v[0] && !bus_req) break;
      end
   endtask

   task automatic wait_lock();
      for (int k = 0; k < 200; k++) begin
         @(negedge clk);
         if (bus_lock) break;
      end
   endtask

   task automatic start_xfer(input int s, input int d, input int cs, input int n, input bit ee);
      for (int i = 0; i < n; i++) begin
         mem[s+i] = 8'($urandom);
         mem[d+i] = ~mem[s+i];
      end
      clear_logs();
      wr_reg(RI_SRC, s);
      wr_reg(RI_DST, d);
      wr_reg(RI_CSZ, cs);
      wr_reg(RI_CNT, n);
      wr_reg(RI_CTL, {30'd0, ee, 1'b1});
   endtask

   function automatic int pattern_bad(input int s, input int d, input int ceff, input int n);
      int rem = n, sp = s, dp = d, k = 0, bad = 0, l;
      while (rem > 0) begin
         l = (rem < ceff) ? rem : ceff;
         for (int i = 0; i < l; i++) begin
            if (k >= 512 || log_we[k] !== 1'b0 || log_addr[k] !== 16'(sp + i)) bad++;
            k++;
         end
         for (int i = 0; i < l; i++) begin
            if (k >= 512 || log_we[k] !== 1'b1 || log_addr[k] !== 16'(dp + i)) bad++;
            k++;
         end
         sp += l; dp += l; rem -= l;
      end
      if (k != log_n) bad++;
      return bad;
   endfunction

   task automatic finish_checks(input int s, input int d, input int ceff, input int n,
                                input bit ee, input string tag);
      logic [31:0] v;
      int bad = 0;
      for (int i = 0; i < n; i++) if (mem[d+i] !== mem[s+i]) bad++;
      chk(bad == 0, {tag, " R5 destination bytes in source order"}, bad, 0);
      bad = pattern_bad(s, d, ceff, n);
      chk(bad == 0, {tag, " R3 R9 access pattern"}, bad, 0);
      chk(lock_rises == (n + ceff - 1) / ceff, {tag, " R4 lock assertions per cluster"},
          lock_rises, (n + ceff - 1) / ceff);
      rd_reg(RI_SRC, v);
      chk(v == 32'(s + n), {tag, " R6 source register after transfer"}, int'(v), s + n);
      rd_reg(RI_DST, v);
      chk(v == 32'(d + n), {tag, " R6 destination register after transfer"}, int'(v), d + n);
      rd_reg(RI_CNT, v);
      chk(v == 0, {tag, " R6 count register after transfer"}, int'(v), 0);
      rd_reg(RI_CTL, v);
      chk(v[0] == 1'b0, {tag, " R7 enable cleared at end"}, int'(v[0]), 0);
      if (ee)
         chk(end_cnt == 1 && end_idx == 2*n - 1, {tag, " R8 end strobe on final write"},
             end_idx, 2*n - 1);
      else
         chk(end_cnt == 0, {tag, " R8 end strobe disabled"}, end_cnt, 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      chk(1'b0, "R7 watchdog expired", 0, 1);
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      logic [31:0] v;
      int s, d, cs, n, ceff;
      bit ee;
      void'($urandom(32'd4711));
      for (int i = 0; i < 1024; i++) mem[i] = 8'h00;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int r = 0; r < 5; r++) begin
         rd_reg(3'(r), v);
         chk(v == 0, "R1 register reset value", int'(v), 0);
      end
      chk(!bus_req && !bus_lock && !xfer_end, "R1 bus idle after reset",
          int'({bus_req, bus_lock, xfer_end}), 0);

      // R7 enable with zero count stays idle
      clear_logs();
      wr_reg(RI_CNT, 0);
      wr_reg(RI_CTL, 1);
      repeat (6) @(negedge clk);
      chk(!bus_req && log_n == 0, "R7 zero count starts no activity", log_n, 0);
      wr_reg(RI_CTL, 0);

      // R9 cluster size one
      start_xfer(10, 600, 1, 6, 1'b1);
      wait_idle();
      finish_checks(10, 600, 1, 6, 1'b1, "size1");

      // R10 size zero acts as one
      start_xfer(40, 640, 0, 4, 1'b0);
      wait_idle();
      finish_checks(40, 640, 1, 4, 1'b0, "size0");

      // R10 oversize clamps to 32
      start_xfer(0, 600, 45, 70, 1'b1);
      wait_idle();
      finish_checks(0, 600, 32, 70, 1'b1, "clamp");

      // R11 stop mid-cluster then resume
      start_xfer(100, 600, 8, 32, 1'b1);
      wait_lock();
      wr_reg(RI_CTL, 32'd2);
      wait_idle();
      repeat (10) @(negedge clk);
      chk(log_n == 16 && !bus_req, "R11 one cluster completes after disable", log_n, 16);
      rd_reg(RI_CNT, v);
      chk(v == 24, "R11 count after stopped cluster", int'(v), 24);
      rd_reg(RI_SRC, v);
      chk(v == 108, "R11 source after stopped cluster", int'(v), 108);
      chk(end_cnt == 0, "R11 R8 no end strobe when stopped early", end_cnt, 0);
      wr_reg(RI_CTL, 32'd3);
      wait_idle();
      finish_checks(100, 600, 8, 32, 1'b1, "resume R11");

      // R12 writes ignored while busy
      start_xfer(200, 700, 5, 23, 1'b0);
      wait_lock();
      wr_reg(RI_SRC, 0);
      wr_reg(RI_DST, 0);
      wr_reg(RI_CNT, 3);
      wr_reg(RI_CSZ, 1);
      wait_idle();
      finish_checks(200, 700, 5, 23, 1'b0, "busywrite R12");

      // constrained random transfers
      for (int t = 0; t < 6; t++) begin
         cs = 1 + int'($urandom % 32);
         n  = 1 + int'($urandom % 80);
         s  = int'($urandom % 400);
         d  = 512 + int'($urandom % 400);
         ee = 1'($urandom % 2);
         ceff = cs;
         start_xfer(s, d, cs, n, ee);
         wait_idle();
         finish_checks(s, d, ceff, n, ee, "random");
      end

      chk(gnt_viol == 0, "R2 lock only after grant", gnt_viol, 0);
      chk(ack_seen == 0, "R13 acknowledge never asserted", ack_seen, 0);

      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule